// File: doc/BRIEF.md
# Bulk-Out Frame Encapsulator

This block sits between a MAC transmit path and a USB bulk-out endpoint buffer. It accepts one Ethernet frame per input packet on a byte stream with a valid/ready handshake. It places a four-byte length header in front of the frame. When the wrapped frame would end exactly on an awkward USB packet boundary, it also appends a constant four-byte trailer.

The declared frame length arrives with the first input beat. The block captures it at that point, together with the maximum USB packet size. From these two values it builds the header and makes the trailer decision, before it accepts any frame byte. If the declared length does not match the number of bytes actually delivered, a one-cycle error pulse is raised. The wrapped frame is still emitted with the header and the trailer decision that the declared length gave.

Top module: `txenc_bulk_encap`

## Requirements
- R1: During and right after a synchronous reset, `out_valid`, `in_ready` and `len_err` are 0.
- R2: Every wrapped frame starts with four header bytes: L[7:0], L[15:8], M[7:0], M[15:8], where L is the declared length and M = L XOR 0xFFFF. No frame byte is accepted before all four header bytes are loaded.
- R3: After the header, the frame bytes appear on `out_data` unchanged and in arrival order. `in_ready` is high only in the frame-body phase.
- R4: When (L + 4) mod (`max_pkt` − 1) equals 0, the bytes 0x00, 0x00, 0xFF, 0xFF follow the last frame byte.
- R5: When that condition does not hold, nothing follows the last frame byte.
- R6: `out_last` is 1 only on the final byte of the wrapped frame. That is the fourth trailer byte when a trailer is added, and the last frame byte otherwise.
- R7: `max_pkt` is sampled once, on the cycle the first beat of a frame is seen. Later changes do not alter the trailer decision for that frame.
- R8: One cycle after the beat carrying `in_last` is accepted, `len_err` pulses for exactly one cycle if the count of accepted bytes differs from L. Otherwise it stays 0.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_data`, `out_last` and `out_valid` hold their values.
- R10: The trailer decision and the header use the declared length L even when the delivered byte count differs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| max_pkt | input | MPS_W | Maximum USB packet size in bytes (at least 2) |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the last byte of the frame |
| in_len | input | LEN_W | Declared frame length, valid with the first beat |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Wrapped stream byte |
| out_last | output | 1 | Final byte of the wrapped frame |
| len_err | output | 1 | One-cycle pulse on a length mismatch |

## Verification
Two events can fall in the same cycle here. The first is acceptance of the final frame byte, which must both choose between trailer and idle and load `out_last`, while the output register is stalled by `out_ready`. The second is the capture of the next frame's length and packet size while the previous frame's last byte still waits in the output register. The bench provokes both by sending frames back to back under a pseudo-random `out_ready` pattern. Every handshaked output byte, its last flag and `len_err` are compared, cycle by cycle, against a queue-based model that computes the wrapped frame from the declared length alone.

// File: rtl/txenc_pkg.sv
package txenc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_BODY = 2'd2,
    ST_PAD  = 2'd3
  } txenc_state_e;

  localparam int WORD_BYTES = 4;
  localparam logic [31:0] TRAILER_WORD = 32'hFFFF_0000;
endpackage

// File: rtl/txenc_lane_sel.sv
module txenc_lane_sel #(
  parameter int LANES = 4,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic [8*LANES-1:0] word,
  input  logic [IDX_W-1:0]   idx,
  output logic [7:0]         byte_o
);
  logic [7:0] lanes [LANES];

  // lane 0 is the least significant byte: little-endian emission
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lanes[g] = word[8*g +: 8];
  end

  assign byte_o = lanes[idx];
endmodule

// File: rtl/txenc_pad_calc.sv
module txenc_pad_calc #(
  parameter int LEN_W = 16,
  parameter int MPS_W = 11,
  localparam int W = ((LEN_W + 1) > MPS_W) ? (LEN_W + 1) : MPS_W
) (
  input  logic [LEN_W-1:0] len,
  input  logic [MPS_W-1:0] mps,
  output logic             pad
);
  logic [W-1:0] total;
  logic [W-1:0] divisor;

  always_comb begin
    total   = W'(len) + W'(4);
    divisor = W'(mps) - W'(1);
    pad     = (divisor != '0) && ((total % divisor) == '0);
  end
endmodule

// File: rtl/txenc_bulk_encap.sv
module txenc_bulk_encap
  import txenc_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int MPS_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MPS_W-1:0] max_pkt,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  input  logic [LEN_W-1:0] in_len,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_last,
  output logic             len_err
);
  localparam int HDR_W = 16;
  localparam int IDX_W = $clog2(WORD_BYTES);
  localparam int CNT_W = LEN_W + 1;

  txenc_state_e     state;
  logic [IDX_W-1:0] idx_q;
  logic [LEN_W-1:0] len_q;
  logic             pad_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ov_q;
  logic [7:0]       od_q;
  logic             ol_q;
  logic             err_q;

  logic             slot;
  logic             pad_now;
  logic [HDR_W-1:0] len16;
  logic [31:0]      hdr_word;
  logic [7:0]       hdr_byte;
  logic [7:0]       trl_byte;
  logic [CNT_W-1:0] cnt_next;

  assign slot     = !ov_q || out_ready;
  assign len16    = HDR_W'(len_q);
  assign hdr_word = {len16 ^ 16'hFFFF, len16};
  assign cnt_next = cnt_q + CNT_W'(1);

  txenc_pad_calc #(.LEN_W(LEN_W), .MPS_W(MPS_W)) u_pad_calc (
    .len (in_len),
    .mps (max_pkt),
    .pad (pad_now)
  );

  txenc_lane_sel #(.LANES(WORD_BYTES)) u_hdr_sel (
    .word   (hdr_word),
    .idx    (idx_q),
    .byte_o (hdr_byte)
  );

  txenc_lane_sel #(.LANES(WORD_BYTES)) u_trl_sel (
    .word   (TRAILER_WORD),
    .idx    (idx_q),
    .byte_o (trl_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      idx_q <= '0;
      len_q <= '0;
      pad_q <= 1'b0;
      cnt_q <= '0;
      ov_q  <= 1'b0;
      od_q  <= '0;
      ol_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (ov_q && out_ready) ov_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (in_valid) begin
            len_q <= in_len;
            pad_q <= pad_now;
            idx_q <= '0;
            cnt_q <= '0;
            state <= ST_HDR;
          end
        end
        ST_HDR: begin
          if (slot) begin
            od_q  <= hdr_byte;
            ov_q  <= 1'b1;
            ol_q  <= 1'b0;
            idx_q <= idx_q + IDX_W'(1);
            if (idx_q == IDX_W'(WORD_BYTES - 1)) state <= ST_BODY;
          end
        end
        ST_BODY: begin
          if (in_valid && slot) begin
            od_q  <= in_data;
            ov_q  <= 1'b1;
            ol_q  <= in_last && !pad_q;
            cnt_q <= cnt_next;
            if (in_last) begin
              err_q <= (cnt_next != CNT_W'(len_q));
              idx_q <= '0;
              state <= pad_q ? ST_PAD : ST_IDLE;
            end
          end
        end
        default: begin
          if (slot) begin
            od_q  <= trl_byte;
            ov_q  <= 1'b1;
            ol_q  <= (idx_q == IDX_W'(WORD_BYTES - 1));
            idx_q <= idx_q + IDX_W'(1);
            if (idx_q == IDX_W'(WORD_BYTES - 1)) state <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign in_ready  = (state == ST_BODY) && slot;
  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign out_last  = ol_q;
  assign len_err   = err_q;
endmodule

// File: rtl/txenc_bulk_encap_chk.sv
module txenc_bulk_encap_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_last,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_last,
  input logic       len_err
);
  logic       rst_q;
  logic [2:0] hcnt;
  logic       out_hs;

  assign out_hs = out_valid && out_ready;

  always_ff @(posedge clk) rst_q <= rst;

  always_ff @(posedge clk) begin
    if (rst) hcnt <= '0;
    else if (out_hs) begin
      if (out_last) hcnt <= '0;
      else if (hcnt != 3'd4) hcnt <= hcnt + 3'd1;
    end
  end

  // R1
  always @(negedge clk) begin
    if (rst_q) begin
      reset_idle_chk: assert (!out_valid && !in_ready && !len_err);
    end
  end

  // R2
  hdr_before_body_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> ((hcnt + {2'b00, out_hs}) >= 3'd4));

  // R3
  ready_needs_slot_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (!out_valid || out_ready));

  // R8
  err_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    len_err |-> $past(in_valid && in_ready && in_last));

  // R8
  err_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    len_err |=> !len_err);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
endmodule

bind txenc_bulk_encap txenc_bulk_encap_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_last   (in_last),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last),
  .len_err   (len_err)
);

// File: tb/txenc_bulk_encap_tb.sv
module txenc_bulk_encap_tb;
  localparam int LEN_W = 16;
  localparam int MPS_W = 11;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [MPS_W-1:0] max_pkt = 11'd64;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [7:0]       in_data = 8'd0;
  logic             in_last = 1'b0;
  logic [LEN_W-1:0] in_len = '0;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic [7:0]       out_data;
  logic             out_last;
  logic             len_err;

  int total = 0;
  int bad = 0;
  int bp_mode = 0;
  int lfsr = 32'h1234_5679;
  bit cur_mismatch = 1'b0;
  bit err_exp = 1'b0;
  bit done = 1'b0;

  logic [8:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  txenc_bulk_encap #(.LEN_W(LEN_W), .MPS_W(MPS_W)) u_dut (
    .clk(clk), .rst(rst), .max_pkt(max_pkt),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .in_len(in_len),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .len_err(len_err)
  );

  // downstream ready pattern, changed just after each rising edge
  always @(posedge clk) begin
    #1;
    lfsr = (lfsr << 1) ^ ((lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]) ? 1 : 0);
    out_ready = (bp_mode == 0) ? 1'b1 : lfsr[3] | lfsr[7];
  end

  // reference comparison on every clock
  always @(negedge clk) begin
    if (!rst && !done) begin
      total++;
      if (len_err !== err_exp) begin
        bad++;
        $display("FAIL R8 len_err actual=%0b expected=%0b", len_err, err_exp);
      end
      err_exp = (in_valid && in_ready && in_last) ? cur_mismatch : 1'b0;
      if (out_valid && out_ready) begin
        total++;
        if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL R5 extra byte actual=%02h expected=none", out_data);
        end else begin
          logic [8:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if ({out_last, out_data} !== e) begin
            bad++;
            $display("FAIL %s byte actual last=%0b data=%02h expected last=%0b data=%02h",
                     t, out_last, out_data, e[8], e[7:0]);
          end
        end
      end
    end
  end

  task automatic push_exp(input logic [7:0] d, input bit l, input string t);
    exp_q.push_back({l, d});
    tag_q.push_back(t);
  endtask

  // decl: declared length, n: bytes actually sent, mps0: size at start,
  // mps1: size driven after the first beat (R7)
  task automatic send_frame(input int decl, input int n, input int mps0,
                            input int mps1, input int seed);
    logic [15:0] l16;
    bit pad;
    l16 = 16'(decl);
    pad = (((decl + 4) % (mps0 - 1)) == 0);
    // R2 header, R10 built from declared length
    push_exp(l16[7:0], 1'b0, "R2");
    push_exp(l16[15:8], 1'b0, "R2");
    push_exp(~l16[7:0], 1'b0, "R2");
    push_exp(~l16[15:8], 1'b0, "R2");
    for (int i = 0; i < n; i++)
      push_exp(8'((i * 7 + seed) & 255), (i == n - 1) && !pad, (i == n - 1) ? "R6" : "R3");
    if (pad) begin
      // R4 trailer bytes, R10 when n differs from decl
      push_exp(8'h00, 1'b0, "R4");
      push_exp(8'h00, 1'b0, "R4");
      push_exp(8'hFF, 1'b0, "R4");
      push_exp(8'hFF, 1'b1, "R6");
    end
    cur_mismatch = (n != decl);
    @(posedge clk); #1;
    max_pkt = MPS_W'(mps0);
    in_len = LEN_W'(decl);
    in_valid = 1'b1;
    for (int i = 0; i < n; i++) begin
      in_data = 8'((i * 7 + seed) & 255);
      in_last = (i == n - 1);
      forever begin
        @(negedge clk);
        if (in_ready) break;
      end
      @(posedge clk); #1;
      if (i == 0) max_pkt = MPS_W'(mps1);
    end
    in_valid = 1'b0;
    in_last = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 5000; k++) begin
      @(posedge clk);
      if (exp_q.size() == 0) break;
    end
    repeat (4) @(posedge clk);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R5 pending bytes actual=%0d expected=0", exp_q.size());
      exp_q.delete();
      tag_q.delete();
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    // R1 reset state
    total++;
    if (out_valid !== 1'b0 || in_ready !== 1'b0 || len_err !== 1'b0) begin
      bad++;
      $display("FAIL R1 actual v=%0b r=%0b e=%0b expected 0 0 0", out_valid, in_ready, len_err);
    end
    send_frame(60, 60, 64, 64, 1);       // R5 no trailer
    send_frame(59, 59, 64, 64, 2);       // R4 trailer at 63
    send_frame(122, 122, 64, 64, 3);     // R4 trailer at 126
    send_frame(507, 507, 512, 512, 4);   // R4 trailer at 511
    send_frame(508, 508, 512, 512, 5);   // R5
    send_frame(1, 1, 512, 512, 6);       // R6 single byte
    drain();
    bp_mode = 1;                         // R9 stalls
    send_frame(1018, 1018, 512, 512, 7); // R4 trailer at 1022
    send_frame(59, 59, 64, 512, 8);      // R7 keeps 64-byte decision
    send_frame(507, 507, 64, 512, 9);    // R7 no trailer under 64
    send_frame(59, 58, 64, 64, 10);      // R8 short, R10 trailer kept
    send_frame(10, 12, 64, 64, 11);      // R8 long
    send_frame(185, 185, 64, 64, 12);    // R4 back to back
    send_frame(40, 40, 64, 64, 13);      // R5
    drain();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(150000 * 10);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule